// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identifier

This block gathers the interrupt conditions of a serial port and turns them into one interrupt request line and an 8-bit identification byte that the CPU reads to learn which condition to service. It ranks five conditions: receiver line errors, received data waiting, character timeout, transmit holding register empty, and modem-line change. The block presents only the most urgent enabled condition at any time.

Line-error, timeout, modem-change and transmit-empty conditions reach the block as single-cycle event pulses, and the block holds each one pending until that source's own clearing access arrives. Received-data-waiting reaches the block as a level, because the receive buffer already knows when it has fallen below its threshold. The CPU access strobes (identification read, line-status read, receive-buffer read, modem-status read, transmit-holding write) are single-cycle pulses, except the identification read. That read may span several cycles: the byte it returns is frozen when the read starts, and any clearing it triggers takes effect when the read ends.

Top module: `irq_ident`

## Requirements
- R1: While reset is asserted and right after it, no source is pending except transmit-empty. With all enables at zero, `iid` reads 0x01 and `irq` is low. Setting only `ier_en[1]` raises `irq` and gives `iid` 0x02.
- R2: `iid[0]` is 0 exactly when an enabled source is pending and 1 otherwise. `iid[5:4]` always read 0. `iid[7:6]` both equal `fifo_on`. `iid[3]` is 0 whenever `fifo_on` is 0.
- R3: `iid[3:0]` carries the code of the highest-ranked enabled pending source. The ranking and codes are, from highest to lowest: line status 0110, timeout 1100, data waiting 0100, transmit empty 0010, modem change 0000. Timeout and data waiting share a level, and timeout is reported when both are active.
- R4: `ier_en[0]` gates both data waiting and timeout. `ier_en[1]` gates transmit empty, `ier_en[2]` gates line status, and `ier_en[3]` gates modem change. A disabled source keeps its pending state but is neither reported nor able to raise `irq`.
- R5: `irq` is high whenever any enabled source is pending. It stays low when all four enables are 0.
- R6: A `line_ev` pulse makes line status pending from the next cycle on. A `lsr_rd` pulse clears it on the next cycle.
- R7: Data waiting follows the `rxdata_lvl` input with no storage in the block.
- R8: Timeout is set by `rxtmo_ev` only while `fifo_on` is 1. A `rbr_rd` pulse clears it, and so does `fifo_on` being 0, so a pulse with FIFOs off is ignored.
- R9: A `modem_ev` pulse makes modem change pending. A `msr_rd` pulse clears it.
- R10: A `thr_wr` pulse clears transmit empty. An identification read also clears it when the read ends, but only if the read reported 0010. Once cleared, transmit empty returns only on a new `txe_ev` pulse.
- R11: During an identification read lasting more than one cycle, `iid` holds the value it had in the first cycle of the read, even if sources change meanwhile.
- R12: When a source's setting event and clearing strobe arrive in the same cycle, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_en | input | 4 | Source enables (bit mapping in R4) |
| fifo_on | input | 1 | FIFO mode active |
| line_ev | input | 1 | Receiver line error event pulse |
| rxdata_lvl | input | 1 | Receive data waiting level |
| rxtmo_ev | input | 1 | Character timeout event pulse |
| modem_ev | input | 1 | Modem line change event pulse |
| txe_ev | input | 1 | Transmit holding became empty, pulse |
| iir_rd | input | 1 | Identification read, held for the read's length |
| lsr_rd | input | 1 | Line status read pulse |
| rbr_rd | input | 1 | Receive buffer read pulse |
| msr_rd | input | 1 | Modem status read pulse |
| thr_wr | input | 1 | Transmit holding write pulse |
| irq | output | 1 | Interrupt request, active high |
| iid | output | 8 | Identification byte |

## Verification
An event pulse or clearing strobe sampled at one rising edge shows on `irq` and `iid` right after that edge, one cycle of latency. Enable bits, `fifo_on` and `rxdata_lvl` act combinationally on the outputs. An identification read freezes `iid` from the edge after its first cycle, and the clear it causes shows after the edge that follows the read's last cycle. The bench drives every input on the falling edge and compares a quarter period after each rising edge, so every expected value refers to the state just updated by that edge.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
  localparam int unsigned IID_W  = 8;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned EN_W   = 4;

  // held-source flag slots
  localparam int unsigned NFLG      = 4;
  localparam int unsigned FLG_LINE  = 0;
  localparam int unsigned FLG_TMO   = 1;
  localparam int unsigned FLG_MODEM = 2;
  localparam int unsigned FLG_TXE   = 3;
  localparam logic [NFLG-1:0] FLG_RST = 4'b1000;

  // enable bit positions
  localparam int unsigned EN_RXDATA = 0;
  localparam int unsigned EN_TXE    = 1;
  localparam int unsigned EN_LINE   = 2;
  localparam int unsigned EN_MODEM  = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE    = 4'b0001,
    CODE_LINE    = 4'b0110,
    CODE_RXDATA  = 4'b0100,
    CODE_RXTMO   = 4'b1100,
    CODE_TXEMPTY = 4'b0010,
    CODE_MODEM   = 4'b0000
  } irq_code_e;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_id_pkg::*;
#(
  parameter int unsigned N = NFLG,
  parameter logic [N-1:0] RST_V = FLG_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_rq,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= RST_V[g];
      else if (set_ev[g]) q <= 1'b1;
      else if (clr_rq[g]) q <= 1'b0;
    end
    assign pend[g] = q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[g] |=> pend[g]); // R12
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rq[g] && !set_ev[g]) |=> !pend[g]); // R6
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[g] && !set_ev[g]) |=> !pend[g]); // R10
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_id_pkg::*;
(
  input  logic [NFLG-1:0]  pend,
  input  logic             rxdata_lvl,
  input  logic [EN_W-1:0]  en,
  input  logic             fifo_on,
  output logic             irq,
  output logic [IID_W-1:0] iid
);
  logic act_line, act_tmo, act_rxd, act_txe, act_ms;
  irq_code_e code;

  always_comb begin
    act_line = pend[FLG_LINE]  & en[EN_LINE];
    act_tmo  = pend[FLG_TMO]   & en[EN_RXDATA] & fifo_on;
    act_rxd  = rxdata_lvl      & en[EN_RXDATA];
    act_txe  = pend[FLG_TXE]   & en[EN_TXE];
    act_ms   = pend[FLG_MODEM] & en[EN_MODEM];
    irq      = act_line | act_tmo | act_rxd | act_txe | act_ms;
    if      (act_line) code = CODE_LINE;
    else if (act_tmo)  code = CODE_RXTMO;
    else if (act_rxd)  code = CODE_RXDATA;
    else if (act_txe)  code = CODE_TXEMPTY;
    else if (act_ms)   code = CODE_MODEM;
    else               code = CODE_NONE;
    iid = {{2{fifo_on}}, 2'b00, code};
  end
endmodule

// File: rtl/irq_rd_snap.sv
module irq_rd_snap
  import irq_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic [IID_W-1:0] live,
  output logic [IID_W-1:0] shown,
  output logic             txe_ack
);
  logic             rd_q;
  logic [IID_W-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      snap <= {{(IID_W-1){1'b0}}, 1'b1};
    end else begin
      rd_q <= rd;
      if (rd && !rd_q) snap <= live;
    end
  end

  assign shown   = (rd && rd_q) ? snap : live;
  assign txe_ack = rd_q && !rd && (snap[CODE_W-1:0] == CODE_TXEMPTY);

  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    txe_ack |-> $fell(rd)); // R10
endmodule

// File: rtl/irq_ident.sv
module irq_ident
  import irq_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_en,
  input  logic             fifo_on,
  input  logic             line_ev,
  input  logic             rxdata_lvl,
  input  logic             rxtmo_ev,
  input  logic             modem_ev,
  input  logic             txe_ev,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             msr_rd,
  input  logic             thr_wr,
  output logic             irq,
  output logic [7:0]       iid
);
  logic [NFLG-1:0]  set_ev, clr_rq, pend;
  logic [IID_W-1:0] live_iid;
  logic             txe_ack;

  always_comb begin
    set_ev            = '0;
    set_ev[FLG_LINE]  = line_ev;
    set_ev[FLG_TMO]   = rxtmo_ev & fifo_on;
    set_ev[FLG_MODEM] = modem_ev;
    set_ev[FLG_TXE]   = txe_ev;
    clr_rq            = '0;
    clr_rq[FLG_LINE]  = lsr_rd;
    clr_rq[FLG_TMO]   = rbr_rd | ~fifo_on;
    clr_rq[FLG_MODEM] = msr_rd;
    clr_rq[FLG_TXE]   = thr_wr | txe_ack;
  end

  irq_src_flags #(.N(NFLG), .RST_V(FLG_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_rq(clr_rq), .pend(pend)
  );

  irq_prio_enc u_enc (
    .pend(pend), .rxdata_lvl(rxdata_lvl), .en(ier_en), .fifo_on(fifo_on),
    .irq(irq), .iid(live_iid)
  );

  irq_rd_snap u_snap (
    .clk(clk), .rst_n(rst_n), .rd(iir_rd), .live(live_iid),
    .shown(iid), .txe_ack(txe_ack)
  );

  AST_BIT0_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_rd |-> (irq == !iid[0])); // R2
  AST_NOFIFO_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && !iir_rd) |-> !iid[3]); // R2
  AST_TMO_FIFO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> !pend[FLG_TMO]); // R8
  AST_ENABLES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en == 4'b0000) |-> !irq); // R5
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && $past(iir_rd) && $past(iir_rd, 2)) |-> $stable(iid)); // R11
endmodule

// File: tb/irq_ident_tb.sv
module irq_ident_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 28;
  // row: en[4], fifo, ev{line,rxd,tmo,modem,txe}, st{lsr,rbr,msr,thr}, irq, iid[8]
  localparam logic [22:0] VEC [NV] = '{
    {4'b0000,1'b0,5'b00000,4'b0000,1'b0,8'h01}, // R5 enables all zero
    {4'b0010,1'b0,5'b00000,4'b0000,1'b1,8'h02}, // R1 txe after reset
    {4'b0010,1'b0,5'b00000,4'b0001,1'b0,8'h01}, // R10 thr write clears
    {4'b1111,1'b0,5'b00010,4'b0000,1'b1,8'h00}, // R9 modem set
    {4'b1111,1'b0,5'b00001,4'b0000,1'b1,8'h02}, // R3 txe over modem
    {4'b1111,1'b0,5'b01000,4'b0000,1'b1,8'h04}, // R7 data waiting
    {4'b1111,1'b0,5'b11000,4'b0000,1'b1,8'h06}, // R3 line highest
    {4'b1011,1'b0,5'b01000,4'b0000,1'b1,8'h04}, // R4 line disabled
    {4'b1111,1'b0,5'b01000,4'b1000,1'b1,8'h04}, // R6 lsr read clears
    {4'b1111,1'b0,5'b00000,4'b0000,1'b1,8'h02}, // R7 level drops
    {4'b1111,1'b0,5'b00000,4'b0001,1'b1,8'h00}, // R10 thr write
    {4'b1111,1'b0,5'b00000,4'b0010,1'b0,8'h01}, // R9 msr read clears
    {4'b0111,1'b0,5'b00010,4'b0000,1'b0,8'h01}, // R4 modem disabled
    {4'b1111,1'b0,5'b00000,4'b0000,1'b1,8'h00}, // R4 modem kept pending
    {4'b1111,1'b0,5'b00010,4'b0010,1'b1,8'h00}, // R12 set beats clear
    {4'b1111,1'b0,5'b00000,4'b0010,1'b0,8'h01}, // R9 clear
    {4'b1111,1'b0,5'b00100,4'b0000,1'b0,8'h01}, // R8 timeout ignored, fifo off
    {4'b1111,1'b1,5'b00000,4'b0000,1'b0,8'hC1}, // R2 fifo idle
    {4'b1111,1'b1,5'b00100,4'b0000,1'b1,8'hCC}, // R8 timeout code
    {4'b1111,1'b1,5'b01000,4'b0000,1'b1,8'hCC}, // R3 timeout over data
    {4'b1110,1'b1,5'b01000,4'b0000,1'b0,8'hC1}, // R4 bit0 gates both
    {4'b1111,1'b1,5'b00000,4'b0100,1'b0,8'hC1}, // R8 rbr read clears
    {4'b1111,1'b1,5'b00100,4'b0000,1'b1,8'hCC}, // R8 set again
    {4'b1111,1'b0,5'b00000,4'b0000,1'b0,8'h01}, // R8 fifo off clears
    {4'b1111,1'b1,5'b00000,4'b0000,1'b0,8'hC1}, // R8 stays cleared
    {4'b1111,1'b1,5'b10000,4'b0000,1'b1,8'hC6}, // R6 line set
    {4'b1111,1'b1,5'b10000,4'b1000,1'b1,8'hC6}, // R12 line set beats read
    {4'b1111,1'b1,5'b00000,4'b1000,1'b0,8'hC1}  // R6 cleared
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier_en = '0;
  logic fifo_on = 0, line_ev = 0, rxdata_lvl = 0, rxtmo_ev = 0, modem_ev = 0, txe_ev = 0;
  logic iir_rd = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic irq;
  logic [7:0] iid;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .fifo_on(fifo_on),
    .line_ev(line_ev), .rxdata_lvl(rxdata_lvl), .rxtmo_ev(rxtmo_ev),
    .modem_ev(modem_ev), .txe_ev(txe_ev), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .rbr_rd(rbr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr), .irq(irq), .iid(iid)
  );

  task automatic chk(input string req, input logic eirq, input logic [7:0] eiid);
    n_chk++;
    if (irq !== eirq || iid !== eiid) begin
      n_bad++;
      $display("FAIL %s: irq=%b iid=%02h expected irq=%b iid=%02h", req, irq, iid, eirq, eiid);
    end
  endtask

  task automatic quiet();
    {line_ev, rxtmo_ev, modem_ev, txe_ev, lsr_rd, rbr_rd, msr_rd, thr_wr} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  initial begin
    #(CLK_P*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*2 + CLK_P/4);
    chk("R1 in reset", 1'b0, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 after reset", 1'b0, 8'h01);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ier_en     = VEC[i][22:19];
      fifo_on    = VEC[i][18];
      {line_ev, rxdata_lvl, rxtmo_ev, modem_ev, txe_ev} = VEC[i][17:13];
      {lsr_rd, rbr_rd, msr_rd, thr_wr} = VEC[i][12:9];
      tick();
      chk($sformatf("vector %0d", i), VEC[i][8], VEC[i][7:0]);
    end

    // R10: read that reports transmit empty clears it at read end
    @(negedge clk); quiet(); fifo_on = 0; ier_en = 4'b1111; txe_ev = 1;
    tick(); chk("R10 txe set", 1'b1, 8'h02);
    @(negedge clk); quiet(); iir_rd = 1;
    tick(); chk("R11 read shows code", 1'b1, 8'h02);
    @(negedge clk); iir_rd = 0;
    tick(); chk("R10 cleared by id read", 1'b0, 8'h01);

    // R10: read reporting a different code leaves transmit empty pending
    @(negedge clk); txe_ev = 1; line_ev = 1;
    tick(); chk("R3 line over txe", 1'b1, 8'h06);
    @(negedge clk); quiet(); iir_rd = 1;
    tick();
    @(negedge clk); iir_rd = 0;
    tick();
    @(negedge clk); lsr_rd = 1;
    tick(); chk("R10 unreported txe kept", 1'b1, 8'h02);

    // R11: code frozen for a long read; R10 clear goes to the reported source
    @(negedge clk); quiet(); iir_rd = 1;
    tick();
    @(negedge clk); line_ev = 1;
    tick(); chk("R11 frozen during read", 1'b1, 8'h02);
    @(negedge clk); quiet(); iir_rd = 0;
    tick(); chk("R11 line visible after read", 1'b1, 8'h06);
    @(negedge clk); lsr_rd = 1;
    tick(); chk("R10 no rearm without event", 1'b0, 8'h01);
    @(negedge clk); quiet(); txe_ev = 1;
    tick(); chk("R10 rearm on new event", 1'b1, 8'h02);
    @(negedge clk); quiet();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule